// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host use an external asynchronous static RAM of 1M words by 16 bits. The host makes a request with a valid/ready handshake, giving a word address, write data, a direction bit and one enable bit per byte lane. A read returns its data with a single-cycle response pulse. The memory side has a pair of chip selects of opposite polarity, write and output strobes, one active-low select per byte lane, the address, and a data bus split into separate out, in and drive-enable signals for the pad ring.

The memory has no clock, so every access is timed by counting controller clock cycles. Each timing limit is turned into a cycle count by dividing its nanosecond value by the clock period and rounding up. The counts are top-level parameters. With a 5 ns clock and the 70 ns grade, the defaults are: a 14-cycle read window, an 11-cycle write pulse, 13 cycles from address valid to the end of a write, 7 cycles of data setup, and 5 cycles for the memory to release the bus after a read. Only one access is in flight at a time. A request is taken only while the controller is idle.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever idle, the memory is in standby. `memSelN`=1, `memSel2`=0, `memWeN`=1, `memOeN`=1, all `memLaneN` bits are 1, `memDqOe`=0, and `reqReady`=1.
- R2: A read keeps both chip selects active and `memOeN` low for exactly RD_CYCLES cycles. During that time `memWeN` is high, `memDqOe` is low and `memAddr` is stable.
- R3: Read data is sampled in the last cycle of the read window. `rspValid` is high for exactly one cycle, RD_CYCLES clock edges after the accepting edge.
- R4: A write has three phases. First comes one setup cycle with `memWeN` high and the bus driven. Then `memWeN` is low for WLOW = max(WP_CYCLES, max(AW_CYCLES, DS_CYCLES) - 1) cycles. Last comes one recovery cycle with `memWeN` high. The chip selects stay active and the data stays driven through all three phases.
- R5: Byte lanes are fixed: `reqBe[0]` drives `memLaneN[0]` and data bits 7:0, and `reqBe[1]` drives `memLaneN[1]` and data bits 15:8. Only enabled lanes are written, and the other lanes of the stored word keep their value.
- R6: When a write is accepted and the previous access was a read, the controller waits TA_CYCLES extra cycles before it drives the bus. The bus is then first driven TA_CYCLES+1 edges after acceptance, instead of 1.
- R7: `reqReady` is high only while idle. A request held during a busy period is taken exactly once, on the first edge where it meets `reqReady`.
- R8: `memAddr` changes only between accesses, never while `memWeN` is low or a read window is open.
- R9: `memDqOe` is never high while `memOeN` is low.
- R10: The two chip selects always agree. `memSelN` is low exactly when `memSel2` is high.
- R11: Data lanes of a read whose `reqBe` bit is 0 return zero in `rspData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte-lane enables |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | DATA_W | Read data, disabled lanes zero |
| memSelN | output | 1 | Active-low chip select |
| memSel2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memLaneN | output | DATA_W/8 | Byte-lane selects, active low |
| memAddr | output | ADDR_W | Memory address |
| memDqOut | output | DATA_W | Data toward the memory |
| memDqIn | input | DATA_W | Data from the memory |
| memDqOe | output | 1 | Drive enable for memDqOut |

## Verification
The bench keeps its own behavioural model, updated at every clock edge, of when each result is due. `reqReady` drops on the accepting edge. It comes back RD_CYCLES edges later for a read, and WLOW+2 edges later for a write, or TA_CYCLES+WLOW+2 when a read came just before. `rspValid` and its data are due exactly RD_CYCLES edges after a read is taken. The bench samples every output on the falling edge that follows, so each comparison sees the value that one rising edge produced. The memory model in the bench gives valid read data only after the select has been held for RD_CYCLES cycles. It keeps driving the bus for TA_CYCLES cycles after a read, and it measures each write pulse. A controller that is early by one cycle therefore reads garbage, collides on the bus, or fails the pulse-width check.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSET,
    ST_WLOW,
    ST_WREC
  } asram_state_e;

  // registered memory-side pin levels
  typedef struct packed {
    logic selN;
    logic sel2;
    logic weN;
    logic oeN;
    logic laneOn;
    logic driveBus;
  } asram_pins_t;

  // everything the control hands to the datapath and top
  typedef struct packed {
    asram_pins_t pins;
    logic        load;
    logic        capture;
  } asram_strobe_t;

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic asram_pins_t pinsFor(input asram_state_e s);
    asram_pins_t p;
    p = '{selN: 1'b1, sel2: 1'b0, weN: 1'b1, oeN: 1'b1, laneOn: 1'b0, driveBus: 1'b0};
    case (s)
      ST_READ: p = '{selN: 1'b0, sel2: 1'b1, weN: 1'b1, oeN: 1'b0, laneOn: 1'b1, driveBus: 1'b0};
      ST_WSET: p = '{selN: 1'b0, sel2: 1'b1, weN: 1'b1, oeN: 1'b1, laneOn: 1'b1, driveBus: 1'b1};
      ST_WLOW: p = '{selN: 1'b0, sel2: 1'b1, weN: 1'b0, oeN: 1'b1, laneOn: 1'b1, driveBus: 1'b1};
      ST_WREC: p = '{selN: 1'b0, sel2: 1'b1, weN: 1'b1, oeN: 1'b1, laneOn: 1'b1, driveBus: 1'b1};
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYCLES   = 14,
  parameter int unsigned WLOW_CYCLES = 12,
  parameter int unsigned TA_CYCLES   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic          reqWrite,
  output logic          reqReady,
  output asram_strobe_t strb
);

  localparam int unsigned CNT_MAX = maxU(maxU(RD_CYCLES, WLOW_CYCLES), TA_CYCLES);
  localparam int CNT_W = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);

  asram_state_e state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic lastRead, nLastRead;
  logic accept, capture;
  asram_pins_t pinQ;

  always_comb begin
    nState    = state;
    nCnt      = cnt;
    nLastRead = lastRead;
    accept    = reqValid && (state == ST_IDLE);
    capture   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (reqWrite) begin
            if (lastRead && (TA_CYCLES > 0)) begin
              nState = ST_TURN;
              nCnt   = CNT_W'(TA_CYCLES - 1);
            end else begin
              nState = ST_WSET;
            end
          end else begin
            nState = ST_READ;
            nCnt   = CNT_W'(RD_CYCLES - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          capture   = 1'b1;
          nState    = ST_IDLE;
          nLastRead = 1'b1;
        end else begin
          nCnt = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) nState = ST_WSET;
        else           nCnt   = cnt - 1'b1;
      end
      ST_WSET: begin
        nState    = ST_WLOW;
        nCnt      = CNT_W'(WLOW_CYCLES - 1);
        nLastRead = 1'b0;
      end
      ST_WLOW: begin
        if (cnt == '0) nState = ST_WREC;
        else           nCnt   = cnt - 1'b1;
      end
      ST_WREC: nState = ST_IDLE;
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lastRead <= 1'b0;
      pinQ     <= pinsFor(ST_IDLE);
    end else begin
      state    <= nState;
      cnt      <= nCnt;
      lastRead <= nLastRead;
      pinQ     <= pinsFor(nState);
    end
  end

  assign reqReady     = (state == ST_IDLE);
  assign strb.pins    = pinQ;
  assign strb.load    = accept;
  assign strb.capture = capture;

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  asram_strobe_t     strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [LANES-1:0]  memLaneN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdQ;
  logic              rvQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      wdQ   <= '0;
      beQ   <= '0;
      rvQ   <= 1'b0;
    end else begin
      rvQ <= strb.capture;
      if (strb.load) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
        beQ   <= reqBe;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)               rdQ[g*8 +: 8] <= 8'h00;
      else if (strb.capture) rdQ[g*8 +: 8] <= beQ[g] ? memDqIn[g*8 +: 8] : 8'h00;
    end
  end

  assign memLaneN = ~(beQ & {LANES{strb.pins.laneOn}});
  assign memAddr  = addrQ;
  assign memDqOut = wdQ;
  assign rspData  = rdQ;
  assign rspValid = rvQ;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int DATA_W          = 16,
  parameter int unsigned RD_CYCLES = 14,
  parameter int unsigned WP_CYCLES = 11,
  parameter int unsigned AW_CYCLES = 13,
  parameter int unsigned DS_CYCLES = 7,
  parameter int unsigned TA_CYCLES = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBe,
  output logic                  rspValid,
  output logic [DATA_W-1:0]     rspData,
  output logic                  memSelN,
  output logic                  memSel2,
  output logic                  memWeN,
  output logic                  memOeN,
  output logic [DATA_W/8-1:0]   memLaneN,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memDqOut,
  input  logic [DATA_W-1:0]     memDqIn,
  output logic                  memDqOe
);

  localparam int LANES = DATA_W / 8;
  // address and data are valid one cycle before the strobe falls
  localparam int unsigned SETUP_NEED  = maxU(AW_CYCLES, DS_CYCLES);
  localparam int unsigned WLOW_CYCLES = maxU(WP_CYCLES, (SETUP_NEED > 1) ? SETUP_NEED - 1 : 1);

  asram_strobe_t strb;

  asram_fsm #(
    .RD_CYCLES  (RD_CYCLES),
    .WLOW_CYCLES(WLOW_CYCLES),
    .TA_CYCLES  (TA_CYCLES)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqBe   (reqBe),
    .memDqIn (memDqIn),
    .rspValid(rspValid),
    .rspData (rspData),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memLaneN(memLaneN)
  );

  assign memSelN = strb.pins.selN;
  assign memSel2 = strb.pins.sel2;
  assign memWeN  = strb.pins.weN;
  assign memOeN  = strb.pins.oeN;
  assign memDqOe = strb.pins.driveBus;

endmodule

// File: rtl/asram_chk.sv
module asram_chk #(
  parameter int ADDR_W = 20,
  parameter int unsigned WLOW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memSelN,
  input logic              memSel2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDqOe
);

  logic [15:0] weLowCnt;

  always_ff @(posedge clk) begin
    if (rst)          weLowCnt <= '0;
    else if (!memWeN) weLowCnt <= (weLowCnt == 16'hFFFF) ? weLowCnt : weLowCnt + 16'd1;
    else              weLowCnt <= '0;
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memSelN && !memSel2 && memWeN && memOeN && !memDqOe)); // R1
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !memOeN |-> (memWeN && !memDqOe)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> !rspValid); // R3
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(memWeN) |-> (weLowCnt >= 16'(WLOW))); // R4
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> (memDqOe && memOeN && !memSelN)); // R4
  AST_ACCEPT_ONCE: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady); // R7
  AST_ADDR_HELD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!memWeN && !$past(rst)) |-> $stable(memAddr)); // R8
  AST_ADDR_HELD_READ: assert property (@(posedge clk) disable iff (rst)
    (!memOeN && $past(!memOeN)) |-> $stable(memAddr)); // R8
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    !(memDqOe && !memOeN)); // R9
  AST_SEL_AGREE: assert property (@(posedge clk) disable iff (rst)
    (memSelN == !memSel2)); // R10

endmodule

bind asram_ctrl asram_chk #(
  .ADDR_W(ADDR_W),
  .WLOW  (WLOW_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memSelN (memSelN),
  .memSel2 (memSel2),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memAddr (memAddr),
  .memDqOe (memDqOe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int NL = DW / 8;
  localparam int RC = 14;
  localparam int TA = 5;
  localparam int WL = 12;   // max(11, max(13,7)-1)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [NL-1:0] reqBe = '0;
  logic reqReady, rspValid, memSelN, memSel2, memWeN, memOeN, memDqOe;
  logic [DW-1:0] rspData, memDqOut;
  logic [DW-1:0] memDqIn = '0;
  logic [NL-1:0] memLaneN;
  logic [AW-1:0] memAddr;

  always #2.5 clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .memSelN(memSelN), .memSel2(memSel2),
    .memWeN(memWeN), .memOeN(memOeN), .memLaneN(memLaneN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqIn(memDqIn), .memDqOe(memDqOe)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] laneMask(input logic [NL-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < NL; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // ---------------- behavioural memory ----------------
  logic [DW-1:0] mem [logic [AW-1:0]];
  int rdCnt = 0, floatCnt = 0, weLow = 0;
  logic [AW-1:0] rdAddr = '0, wAddr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      bit sel, rdAct;
      logic [DW-1:0] word;
      sel   = !memSelN && memSel2;
      rdAct = sel && !memOeN && memWeN;
      if (rdAct) begin
        if (rdCnt > 0 && memAddr == rdAddr) rdCnt++;
        else begin rdCnt = 1; rdAddr = memAddr; end
      end else rdCnt = 0;
      if (rdAct) floatCnt = TA;
      else if (floatCnt > 0) floatCnt--;
      if ((rdAct || floatCnt > 0) && memDqOe)
        chk(0, "R6 bus driven while memory still drives", 32'(memDqOe), 0);
      word = mem.exists(memAddr) ? mem[memAddr] : '0;
      for (int i = 0; i < NL; i++)
        memDqIn[i*8 +: 8] = (rdAct && rdCnt >= RC && !memLaneN[i]) ? word[i*8 +: 8] : 8'hA5;
      if (sel && !memWeN) begin
        if (weLow == 0) wAddr = memAddr;
        else if (memAddr != wAddr) chk(0, "R8 address moved in write", 32'(memAddr), 32'(wAddr));
        if (!memDqOe) chk(0, "R4 bus not driven in write", 0, 1);
        weLow++;
      end else if (weLow > 0) begin
        logic [DW-1:0] cur;
        chk(weLow >= WL, "R4 write pulse width", 32'(weLow), 32'(WL));
        chk(sel && memDqOe, "R4 recovery keeps select and data", 32'({sel, memDqOe}), 3);
        cur = mem.exists(wAddr) ? mem[wAddr] : '0;
        for (int i = 0; i < NL; i++)
          if (!memLaneN[i]) cur[i*8 +: 8] = memDqOut[i*8 +: 8];
        mem[wAddr] = cur;
        weLow = 0;
      end
    end
  end

  // ---------------- cycle reference model ----------------
  logic [DW-1:0] sb [logic [AW-1:0]];
  int busy = 0, pend = 0;
  bit lastRd = 0, expRv = 0;
  logic [DW-1:0] expData = '0;

  always @(posedge clk) begin
    if (rst) begin
      busy = 0; pend = 0; lastRd = 0; expRv = 0;
    end else begin
      bit acc;
      logic [DW-1:0] w, m;
      acc = reqValid && (busy == 0);
      if (busy > 0) busy--;
      expRv = 0;
      if (pend > 0) begin pend--; if (pend == 0) expRv = 1; end
      if (acc) begin
        w = sb.exists(reqAddr) ? sb[reqAddr] : '0;
        m = laneMask(reqBe);
        if (reqWrite) begin
          busy = (lastRd ? TA : 0) + WL + 2;
          sb[reqAddr] = (w & ~m) | (reqWdata & m);
          lastRd = 0;
        end else begin
          busy = RC; pend = RC;
          expData = w & m;
          lastRd = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(reqReady == (busy == 0), "R7 ready", 32'(reqReady), 32'(busy == 0));
      chk(rspValid == expRv, "R3 response timing", 32'(rspValid), 32'(expRv));
      if (expRv) chk(rspData == expData, "R5/R11 read data", 32'(rspData), 32'(expData));
      chk(memSelN == !memSel2, "R10 select pair", 32'({memSelN, memSel2}), 32'({memSelN, !memSelN}));
      if (!memOeN) chk(memWeN && !memDqOe, "R2 read window strobes", 32'({memWeN, memDqOe}), 2);
      if (!memOeN) chk(!memDqOe, "R9 no drive during output enable", 32'(memDqOe), 0);
    end
  end

  // ---------------- stimulus ----------------
  bit prevRead = 0;

  task automatic doOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NL-1:0] be);
    int gap;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (wr) begin
      gap = 1;
      while (!memDqOe && gap < 100) begin @(negedge clk); gap++; end
      chk(gap == (prevRead ? TA + 1 : 1), "R6 write drive delay", 32'(gap), 32'(prevRead ? TA + 1 : 1));
    end
    prevRead = !wr;
  endtask

  task automatic settle();
    while (!reqReady) @(negedge clk);
    repeat (RC + 2) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset / standby
    chk(memSelN && !memSel2 && memWeN && memOeN && !memDqOe, "R1 standby pins",
        32'({memSelN, memSel2, memWeN, memOeN, memDqOe}), 32'b10110);
    chk(memLaneN == '1, "R1 lanes high", 32'(memLaneN), 32'(2'b11));
    chk(reqReady && !rspValid, "R1 ready after reset", 32'({reqReady, rspValid}), 2);

    // R4 full word write, R3 read back
    doOp(1, 20'h00010, 16'hBEEF, 2'b11);
    doOp(0, 20'h00010, 16'h0000, 2'b11);
    // R5 lane writes
    doOp(1, 20'h00010, 16'h1234, 2'b01);   // low lane only
    doOp(1, 20'h00010, 16'h5678, 2'b10);   // high lane only (after write: no turnaround)
    doOp(0, 20'h00010, 16'h0000, 2'b11);   // expect 56 34
    // R11 masked reads
    doOp(0, 20'h00010, 16'h0000, 2'b01);
    doOp(0, 20'h00010, 16'h0000, 2'b10);
    // R6 write right after read, R8 extreme addresses
    doOp(1, 20'hFFFFF, 16'hA55A, 2'b11);
    doOp(0, 20'hFFFFF, 16'h0000, 2'b11);
    doOp(1, 20'h00000, 16'h0F0F, 2'b11);
    doOp(0, 20'h00000, 16'h0000, 2'b11);
    doOp(1, 20'h00000, 16'hFFFF, 2'b00);   // R5 no lane enabled: nothing changes
    doOp(0, 20'h00000, 16'h0000, 2'b11);
    settle();

    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      int r;
      r = $urandom % 16;
      a = (r[3]) ? (20'hFFFF8 | AW'(r[2:0])) : AW'(r[2:0]);
      doOp(bit'($urandom % 2), a, 16'($urandom), 2'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    settle();

    done = 1;
    summary();
    $finish;
  end

endmodule